// File: doc/BRIEF.md
# Timer Input Capture Channel

This block watches one event source and, when a qualified event arrives, copies the current count of one of two free-running 16-bit timers into a capture register. The event source is normally an asynchronous input pin, which is brought into the clock domain and edge-detected. When the alternate-trigger enable is set, a one-cycle "message received" pulse replaces the pin.

A 4-bit mode field chooses what counts as a qualified event. The choices are every falling edge, every rising edge, every 4th rising edge and every 16th rising edge. Any other code turns capture off. Each capture sets a sticky flag that software clears with a write-one-to-clear strobe. A newer capture overwrites an older value that has not been read.

The prescaler counter is cleared only while the mode field holds a non-capture code. Software that wants a clean start with a new ratio therefore passes through an off code. Moving straight from one capture code to another keeps the count, so the first capture after the switch can arrive early.

Top module: `tcap_top`

## Requirements
- R1: While reset is asserted and immediately after it, `cap_val` reads 0 and `cap_flag` reads 0.
- R2: With mode code 4'b0101 and the pin as source, every rising pin edge causes a capture. The captured value is visible on the third rising clock edge after the pin change is sampled.
- R3: With mode code 4'b0100 and the pin as source, every falling pin edge causes a capture and rising edges do not.
- R4: With mode code 4'b0110, every 4th qualifying rising edge causes a capture, counted from a cleared prescaler.
- R5: With mode code 4'b0111, every 16th qualifying rising edge causes a capture, counted from a cleared prescaler.
- R6: `tsel`=0 captures `tmr_a` and `tsel`=1 captures `tmr_b`. The value taken is the one present in the clock cycle of the qualified event.
- R7: A capture sets `cap_flag`. The flag then stays set until a cycle with `flag_clr`=1 and no capture. If a capture and `flag_clr` fall in the same cycle, the flag stays set.
- R8: A capture overwrites the captured value even when the flag from the previous capture is still set. With no capture, `cap_val` holds its value.
- R9: Mode codes outside 4'b0100..4'b0111 produce no capture. They also hold the prescaler at zero, so a following 4'b0110 needs a full 4 edges.
- R10: Changing directly from 4'b0111 to 4'b0110 keeps the prescaler count. After 7 edges under 4'b0111, one more edge under 4'b0110 captures.
- R11: With `alt_en`=1, pin edges cause no capture. Each `msg_rx` pulse counts as an event: codes 4'b0100 and 4'b0101 both capture on every pulse, and 4'b0110 captures on every 4th pulse. The value is visible one clock edge after the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 4 | Capture mode code |
| alt_en | input | 1 | 1: `msg_rx` is the event source instead of the pin |
| tsel | input | 1 | Timer select, 0 = `tmr_a`, 1 = `tmr_b` |
| flag_clr | input | 1 | Write-one-to-clear strobe for `cap_flag` |
| evt_pin | input | 1 | Asynchronous event pin |
| msg_rx | input | 1 | One-cycle message-received pulse |
| tmr_a | input | 16 | Count of timer A |
| tmr_b | input | 16 | Count of timer B |
| cap_val | output | 16 | Captured timer value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
A pin change driven between clock edges reaches the capture register on the third rising edge after it. The first two edges fill the two-flop synchronizer and the third loads the value. The bench therefore waits three falling edges after each pin change before it samples. A `msg_rx` pulse is not synchronized, so its result is due one edge later and is sampled at the next falling edge. Flag clears take effect on the next edge. Timer inputs stay constant from the stimulus until the sample, so the cycle in which the capture lands cannot change the expected value.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam logic [3:0] MODE_FALL  = 4'b0100;
  localparam logic [3:0] MODE_RISE  = 4'b0101;
  localparam logic [3:0] MODE_DIV4  = 4'b0110;
  localparam logic [3:0] MODE_DIV16 = 4'b0111;
  localparam int         DIV4_BITS  = 2;
  localparam int         DIV16_BITS = 4;

  function automatic logic is_capture(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction
endpackage

// File: rtl/tcap_edge.sv
module tcap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tcap_presc.sv
module tcap_presc
  import tcap_pkg::*;
#(
  parameter int PSC_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       alt_en,
  input  logic       pin_rise,
  input  logic       pin_fall,
  input  logic       msg_pulse,
  output logic       fire
);
  logic [PSC_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             active;
  logic             evt;
  logic             wrap;

  always_comb begin
    active = is_capture(mode);
    if (alt_en)                evt = msg_pulse;
    else if (mode == MODE_FALL) evt = pin_fall;
    else                       evt = pin_rise;

    unique case (mode)
      MODE_DIV4:  wrap = &cnt_q[DIV4_BITS-1:0];
      MODE_DIV16: wrap = &cnt_q[DIV16_BITS-1:0];
      default:    wrap = 1'b1;
    endcase

    fire   = active & evt & wrap;
    cnt_en = ~active | evt;
    if (!active || fire) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tcap_hold.sv
module tcap_hold #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          tsel,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  input  logic          flag_clr,
  output logic [TW-1:0] cap_val,
  output logic          cap_flag
);
  logic [TW-1:0] val_q, val_d;
  logic          flag_q, flag_d;

  always_comb begin
    val_d  = tsel ? tmr_b : tmr_a;
    flag_d = fire | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val_q <= '0;
    else if (fire) val_q <= val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign cap_val  = val_q;
  assign cap_flag = flag_q;
endmodule

// File: rtl/tcap_top.sv
module tcap_top #(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PSC_W       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic          alt_en,
  input  logic          tsel,
  input  logic          flag_clr,
  input  logic          evt_pin,
  input  logic          msg_rx,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  output logic [TW-1:0] cap_val,
  output logic          cap_flag
);
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  logic       pin_rise, pin_fall;
  logic       fire_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  tcap_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_ni), .din(evt_pin),
    .rise(pin_rise), .fall(pin_fall)
  );

  tcap_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst_n(rst_ni), .mode(mode), .alt_en(alt_en),
    .pin_rise(pin_rise), .pin_fall(pin_fall), .msg_pulse(msg_rx),
    .fire(fire_w)
  );

  tcap_hold #(.TW(TW)) u_hold (
    .clk(clk), .rst_n(rst_ni), .fire(fire_w), .tsel(tsel),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .flag_clr(flag_clr),
    .cap_val(cap_val), .cap_flag(cap_flag)
  );
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic          alt_en,
  input logic          msg_rx,
  input logic          tsel,
  input logic          flag_clr,
  input logic [TW-1:0] tmr_a,
  input logic [TW-1:0] tmr_b,
  input logic          fire,
  input logic [TW-1:0] cap_val,
  input logic          cap_flag
);
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cap_flag);
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);
  p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !fire) |=> !cap_flag);
  p_val_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cap_val == ($past(tsel) ? $past(tmr_b) : $past(tmr_a)));
  p_val_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(cap_val));
  p_off_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b01) |-> !fire);
  p_alt_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_en && !msg_rx) |-> !fire);
endmodule

bind tcap_top tcap_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_ni), .mode(mode), .alt_en(alt_en), .msg_rx(msg_rx),
  .tsel(tsel), .flag_clr(flag_clr), .tmr_a(tmr_a), .tmr_b(tmr_b),
  .fire(fire_w), .cap_val(cap_val), .cap_flag(cap_flag)
);

// File: tb/test_tcap_top.sv
module test_tcap_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  mode;
  logic        alt_en, tsel, flag_clr, evt_pin, msg_rx;
  logic [15:0] tmr_a, tmr_b;
  logic [15:0] cap_val;
  logic        cap_flag;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  logic [15:0] exp_val;

  always #4 clk = ~clk;

  tcap_top i_tcap_top (
    .clk(clk), .rst_n(rst_n), .mode(mode), .alt_en(alt_en), .tsel(tsel),
    .flag_clr(flag_clr), .evt_pin(evt_pin), .msg_rx(msg_rx),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .cap_val(cap_val), .cap_flag(cap_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pin_edge(input logic v, input logic [15:0] val);
    @(negedge clk);
    evt_pin = v; tmr_a = val; tmr_b = ~val;
    repeat (3) @(negedge clk);
  endtask

  task automatic msg_pulse(input logic [15:0] val);
    @(negedge clk);
    msg_rx = 1'b1; tmr_a = val; tmr_b = ~val;
    @(negedge clk);
    msg_rx = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic fresh_mode(input logic [3:0] m);
    @(negedge clk); mode = 4'b0000;
    @(negedge clk); mode = m;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 4'b0000; alt_en = 1'b0; tsel = 1'b0; flag_clr = 1'b0;
    evt_pin = 1'b0; msg_rx = 1'b0; tmr_a = 16'h0; tmr_b = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 val in reset", cap_val, 16'h0);
    chk("R1 flag in reset", cap_flag, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 val after reset", cap_val, 16'h0);
    chk("R1 flag after reset", cap_flag, 1'b0);
    exp_val = 16'h0;

    // Sweep all capture codes and both timer selects (R2..R7)
    for (int m = 4; m <= 7; m++) begin
      for (int ts = 0; ts <= 1; ts++) begin
        int ratio;
        int cnt_m;
        string req;
        ratio = (m == 6) ? 4 : (m == 7) ? 16 : 1;
        req = (m == 4) ? "R3" : (m == 5) ? "R2" : (m == 6) ? "R4" : "R5";
        tsel = ts[0];
        fresh_mode(m[3:0]);
        cnt_m = 0;
        for (int i = 0; i < 34; i++) begin
          for (int e = 1; e >= 0; e--) begin
            logic [15:0] val;
            bit hit;
            val = 16'h1000 + 16'(m * 256 + ts * 128 + i * 2 + e);
            pin_edge(e[0], val);
            hit = 0;
            if ((m == 4) == (e == 0)) begin
              cnt_m++;
              if (cnt_m == ratio) begin hit = 1; cnt_m = 0; end
            end
            if (hit) exp_val = ts ? ~val : val;
            chk(ts ? "R6 value" : req, cap_val, exp_val);
            chk({req, " flag"}, cap_flag, hit);
            if (hit) begin
              clear_flag();
              chk("R7 flag cleared", cap_flag, 1'b0);
            end
          end
        end
      end
    end

    // R8: overwrite while flag still set; flag sticky without clear
    tsel = 1'b0;
    fresh_mode(4'b0101);
    pin_edge(1'b1, 16'hA001); pin_edge(1'b0, 16'hA002);
    chk("R7 flag set", cap_flag, 1'b1);
    pin_edge(1'b1, 16'hA003); pin_edge(1'b0, 16'hA004);
    chk("R8 overwrite", cap_val, 16'hA003);
    repeat (5) @(negedge clk);
    chk("R7 flag sticky", cap_flag, 1'b1);
    chk("R8 hold", cap_val, 16'hA003);
    clear_flag();

    // R9: off codes capture nothing and hold prescaler at zero
    @(negedge clk); mode = 4'b0000;
    for (int i = 0; i < 5; i++) begin
      pin_edge(1'b1, 16'hB000 + 16'(i)); pin_edge(1'b0, 16'hB100);
    end
    chk("R9 no capture 0000", cap_val, 16'hA003);
    chk("R9 no flag 0000", cap_flag, 1'b0);
    @(negedge clk); mode = 4'b1101;
    pin_edge(1'b1, 16'hB200); pin_edge(1'b0, 16'hB201);
    chk("R9 no capture 1101", cap_val, 16'hA003);
    @(negedge clk); mode = 4'b0000;
    @(negedge clk); mode = 4'b0110;
    for (int i = 1; i <= 4; i++) begin
      pin_edge(1'b1, 16'hC000 + 16'(i)); pin_edge(1'b0, 16'hC100);
      chk("R9 full ratio after off", cap_val, (i == 4) ? 16'hC004 : 16'hA003);
    end
    clear_flag();

    // R10: direct switch keeps prescaler count
    fresh_mode(4'b0111);
    for (int i = 0; i < 7; i++) begin
      pin_edge(1'b1, 16'hD000 + 16'(i)); pin_edge(1'b0, 16'hD100);
    end
    chk("R10 no capture yet", cap_val, 16'hC004);
    @(negedge clk); mode = 4'b0110;
    pin_edge(1'b1, 16'hD777); pin_edge(1'b0, 16'hD800);
    chk("R10 early capture", cap_val, 16'hD777);
    chk("R10 flag", cap_flag, 1'b1);
    clear_flag();

    // R11: alternate trigger
    @(negedge clk); alt_en = 1'b1; mode = 4'b0101;
    pin_edge(1'b1, 16'hE000); pin_edge(1'b0, 16'hE001);
    chk("R11 pin ignored", cap_val, 16'hD777);
    chk("R11 pin ignored flag", cap_flag, 1'b0);
    msg_pulse(16'hE100);
    chk("R11 code 0101 msg", cap_val, 16'hE100);
    fresh_mode(4'b0100);
    msg_pulse(16'hE200);
    chk("R11 code 0100 msg", cap_val, 16'hE200);
    // capture and clear in the same cycle: flag stays set (R7)
    @(negedge clk); msg_rx = 1'b1; flag_clr = 1'b1; tmr_a = 16'hE300; tmr_b = ~16'hE300;
    @(negedge clk); msg_rx = 1'b0; flag_clr = 1'b0;
    chk("R7 capture beats clear", cap_flag, 1'b1);
    chk("R11 value with clear", cap_val, 16'hE300);
    clear_flag();
    fresh_mode(4'b0110);
    for (int i = 1; i <= 8; i++) begin
      msg_pulse(16'hF000 + 16'(i));
      chk("R11 every 4th msg", cap_val,
          (i >= 8) ? 16'hF008 : (i >= 4) ? 16'hF004 : 16'hE300);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule